// File: doc/BRIEF.md
# Cylindrical Matrix Multiplication Array

This block forms the product C = A x B of two square matrices of order N (three by default) on an N-by-N grid of multiply-accumulate cells. Each row of cells is closed into a ring, so the grid is a cylinder. A product is loaded in N input beats. Beat t carries column t of A, one element per row, and row t of B, one element per column. Each A element goes to every cell of its row. The B row enters every ring at an offset that depends on the row, so cell k of ring i always receives the B element for result column (i+k) mod N. No beat carries padding zeros, and after the N-th beat every cell holds one complete element of C.

The results leave as cyclic diagonals. For output group d, lane i carries C[i][(i+d) mod N] together with its row and column tags. Between groups each ring rotates its accumulators by one place, so the next diagonal reaches the head cell. Both the input and the output use valid/ready. A beat is taken on a cycle where in_valid and in_ready are both high. A group is taken on a cycle where out_valid and out_ready are both high. While out_ready is low, the group on the output holds. A one-cycle done pulse marks the end of a product, and a new product may start in that same cycle.

Top module: `cyl_matmul`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and done is 0.
- R2: A beat is accepted on a rising edge where in_valid and in_ready are both 1. In the t-th accepted beat (t = 0..N-1), lane i of in_a (bits [i*DW +: DW]) holds A[i][t] and lane j of in_b holds B[t][j]. Both are signed two's complement. Exactly N beats form one product, with no padding beats.
- R3: From the edge that accepts the N-th beat until done, in_ready is 0. in_ready and out_valid are never high together.
- R4: Output group d (d = 0..N-1) has lane i of out_data (bits [i*AW +: AW]) equal to the signed value of C[i][(i+d) mod N]. Lane i of out_row (bits [i*IW +: IW]) is i. Lane i of out_col is (i+d) mod N. Tags are zero-based.
- R5: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_row and out_col hold their values.
- R6: The first group is valid in the cycle after the N-th beat is accepted. With out_ready held at 1, the N groups appear on N consecutive cycles, so one product takes 2N cycles from its first beat to its last group.
- R7: done is 1 for exactly one cycle, in the cycle after the last group is accepted. In that cycle in_ready is already 1 again.
- R8: Idle cycles between input beats (in_valid low) do not change the result. in_valid held high while groups are draining is not accepted and changes neither the groups in flight nor the next product.
- R9: Each product starts from cleared accumulators. Nothing from an earlier product carries into a later one.
- R10: Products of extreme operands, such as -128 x -128 summed N times or 127 x -128 summed N times, come out exact in the AW-bit signed result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can take an input beat |
| in_a | input | N*DW | One column of A, lane i = row i |
| in_b | input | N*DW | One row of B, lane j = column j |
| out_valid | output | 1 | Output group present |
| out_ready | input | 1 | Consumer takes the output group |
| out_data | output | N*AW | One cyclic diagonal of C |
| out_row | output | N*IW | Row tag of each lane |
| out_col | output | N*IW | Column tag of each lane |
| done | output | 1 | One-cycle pulse after the last group |

## Verification
Each result group is due a fixed number of cycles after its stimulus. Group 0 is due one cycle after the edge that accepts the N-th beat. Each later group is due one cycle after the edge that accepts the group before it, and done is due one cycle after the last group is accepted. The bench drives on falling edges and samples on the falling edge that follows each such rising edge. It checks out_valid in exactly that cycle rather than waiting for it. A run of held cycles under out_ready low confirms that a stalled group does not move, and idle gaps on the input side confirm that the results are the same.

// File: rtl/cyl_pkg.sv
package cyl_pkg;

  typedef enum logic {
    ST_LOAD  = 1'b0,
    ST_DRAIN = 1'b1
  } cyl_state_e;

  // position on a ring of n places, offset from a base place
  function automatic int ring_idx(input int base, input int off, input int n);
    return (base + off) % n;
  endfunction

endpackage

// File: rtl/cyl_mac_cell.sv
module cyl_mac_cell #(
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mac_en,
  input  logic                 clr,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic        [AW-1:0] shift_in,
  output logic        [AW-1:0] acc
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic        [AW-1:0] prod_ext;

  assign prod     = a * b;
  assign prod_ext = {{(AW - PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (mac_en) begin
      acc <= (clr ? '0 : acc) + prod_ext;
    end else if (shift_en) begin
      acc <= shift_in;
    end
  end
endmodule

// File: rtl/cyl_row_ring.sv
module cyl_row_ring #(
  parameter int N   = 3,
  parameter int DW  = 8,
  parameter int AW  = 20,
  parameter int ROW = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mac_en,
  input  logic            clr,
  input  logic            shift_en,
  input  logic [DW-1:0]   a_in,
  input  logic [N*DW-1:0] b_row,
  output logic [AW-1:0]   head
);
  logic [AW-1:0] acc_v [N];

  for (genvar k = 0; k < N; k++) begin : g_cell
    localparam int BSEL = cyl_pkg::ring_idx(ROW, k, N);
    localparam int NXT  = cyl_pkg::ring_idx(k, 1, N);

    cyl_mac_cell #(.DW(DW), .AW(AW)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .mac_en   (mac_en),
      .clr      (clr),
      .shift_en (shift_en),
      .a        (a_in),
      .b        (b_row[BSEL*DW +: DW]),
      .shift_in (acc_v[NXT]),
      .acc      (acc_v[k])
    );
  end

  assign head = acc_v[0];
endmodule

// File: rtl/cyl_seq.sv
module cyl_seq #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          mac_en,
  output logic          clr,
  output logic          shift_en,
  output logic [IW-1:0] diag,
  output logic          done
);
  import cyl_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  cyl_state_e    state;
  logic [IW-1:0] cnt;
  logic          in_fire;
  logic          out_fire;

  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_DRAIN);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign mac_en    = in_fire;
  assign clr       = in_fire && (cnt == '0);
  assign shift_en  = out_fire;
  assign diag      = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_LOAD;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_fire) begin
        if (cnt == LAST) begin
          cnt   <= '0;
          state <= ST_DRAIN;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (out_fire) begin
        if (cnt == LAST) begin
          cnt   <= '0;
          state <= ST_LOAD;
          done  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cyl_matmul.sv
module cyl_matmul #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int AW = 20,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [N*DW-1:0] in_a,
  input  logic [N*DW-1:0] in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [N*AW-1:0] out_data,
  output logic [N*IW-1:0] out_row,
  output logic [N*IW-1:0] out_col,
  output logic            done
);
  logic          mac_en;
  logic          clr;
  logic          shift_en;
  logic [IW-1:0] diag;

  cyl_seq #(.N(N), .IW(IW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .mac_en    (mac_en),
    .clr       (clr),
    .shift_en  (shift_en),
    .diag      (diag),
    .done      (done)
  );

  for (genvar i = 0; i < N; i++) begin : g_row
    cyl_row_ring #(.N(N), .DW(DW), .AW(AW), .ROW(i)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .mac_en   (mac_en),
      .clr      (clr),
      .shift_en (shift_en),
      .a_in     (in_a[i*DW +: DW]),
      .b_row    (in_b),
      .head     (out_data[i*AW +: AW])
    );

    assign out_row[i*IW +: IW] = IW'(i);
    assign out_col[i*IW +: IW] = IW'((i + int'(diag)) % N);
  end
endmodule

// File: rtl/cyl_matmul_chk.sv
module cyl_matmul_chk #(
  parameter int N  = 3,
  parameter int AW = 20,
  parameter int IW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [N*AW-1:0] out_data,
  input logic [N*IW-1:0] out_col,
  input logic            done
);
  int grp_cnt;
  int beat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_cnt  <= 0;
      beat_cnt <= 0;
    end else if (done) begin
      grp_cnt  <= 0;
      beat_cnt <= (in_valid && in_ready) ? 1 : 0;
    end else begin
      if (out_valid && out_ready) grp_cnt  <= grp_cnt + 1;
      if (in_valid && in_ready)   beat_cnt <= beat_cnt + 1;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R3

  AST_BEATS_BEFORE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> beat_cnt == N); // R2

  AST_HOLD_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_col)); // R5

  AST_FIRST_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_col[IW-1:0] == '0); // R4

  AST_GROUP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> grp_cnt == N); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready && !out_valid); // R7

  for (genvar l = 0; l + 1 < N; l++) begin : g_lane
    AST_DIAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> int'(out_col[(l+1)*IW +: IW]) == (int'(out_col[l*IW +: IW]) + 1) % N); // R4
  end
endmodule

bind cyl_matmul cyl_matmul_chk #(.N(N), .AW(AW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_col   (out_col),
  .done      (done)
);

// File: tb/cyl_matmul_tb.sv
module cyl_matmul_tb;
  localparam int N  = 3;
  localparam int DW = 8;
  localparam int AW = 20;
  localparam int IW = 2;
  localparam int NCASE = 4;

  // table: A then B, row-major, per case
  localparam int TAB_A [NCASE][N*N] = '{
    '{1, 0, 0, 0, 1, 0, 0, 0, 1},
    '{-128, -128, -128, -128, -128, -128, -128, -128, -128},
    '{127, 127, 127, 127, 127, 127, 127, 127, 127},
    '{3, -7, 12, 0, 55, -1, -90, 4, 8}
  };
  localparam int TAB_B [NCASE][N*N] = '{
    '{5, -6, 7, 8, 9, -10, 11, 12, 13},
    '{-128, -128, -128, -128, -128, -128, -128, -128, -128},
    '{-128, -128, -128, -128, -128, -128, -128, -128, -128},
    '{-2, 33, 6, 100, -5, 9, 1, 1, -77}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [N*DW-1:0] in_a;
  logic [N*DW-1:0] in_b;
  logic            out_valid;
  logic            out_ready;
  logic [N*AW-1:0] out_data;
  logic [N*IW-1:0] out_row;
  logic [N*IW-1:0] out_col;
  logic            done;

  cyl_matmul #(.N(N), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_row(out_row), .out_col(out_col), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int ma [N][N];
  int mb [N][N];
  int mc [N][N];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ref_mul();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        mc[i][j] = 0;
        for (int t = 0; t < N; t++) mc[i][j] += ma[i][t] * mb[t][j];
      end
  endtask

  function automatic int lane_val(input int i);
    logic signed [AW-1:0] v;
    v = out_data[i*AW +: AW];
    return int'(v);
  endfunction

  // gap: idle cycles before each beat; stall_d: group held 3 cycles (-1 none);
  // junk: in_valid kept high with garbage while draining
  task automatic run_product(input int gap, input int stall_d, input bit junk);
    logic [N*AW-1:0] snap_d;
    logic [N*IW-1:0] snap_c;
    ref_mul();
    for (int t = 0; t < N; t++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_a = '1;
        in_b = '1;
        @(posedge clk);
      end
      @(negedge clk);
      chk(in_ready == 1'b1, "R2", "in_ready during load", int'(in_ready), 1);
      in_valid = 1'b1;
      for (int i = 0; i < N; i++) begin
        in_a[i*DW +: DW] = DW'(ma[i][t]);
        in_b[i*DW +: DW] = DW'(mb[t][i]);
      end
      @(posedge clk);
    end
    for (int d = 0; d < N; d++) begin
      @(negedge clk);
      if (junk) begin
        in_valid = (d != N - 1);
        in_a = $urandom();
        in_b = $urandom();
      end else begin
        in_valid = 1'b0;
      end
      chk(out_valid == 1'b1, "R6", $sformatf("group %0d due", d), int'(out_valid), 1);
      chk(in_ready == 1'b0, "R3", "in_ready low while draining", int'(in_ready), 0);
      if (d == stall_d) begin
        out_ready = 1'b0;
        snap_d = out_data;
        snap_c = out_col;
        for (int s = 0; s < 3; s++) begin
          @(posedge clk);
          @(negedge clk);
          chk(out_valid && out_data == snap_d && out_col == snap_c, "R5",
              "group held under back-pressure", int'(out_valid), 1);
        end
        out_ready = 1'b1;
      end
      for (int i = 0; i < N; i++) begin
        int jc;
        jc = (i + d) % N;
        chk(lane_val(i) == mc[i][jc], "R4", $sformatf("C[%0d][%0d]", i, jc),
            lane_val(i), mc[i][jc]);
        chk(int'(out_row[i*IW +: IW]) == i, "R4", "row tag",
            int'(out_row[i*IW +: IW]), i);
        chk(int'(out_col[i*IW +: IW]) == jc, "R4", "column tag",
            int'(out_col[i*IW +: IW]), jc);
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(done == 1'b1, "R7", "done after last group", int'(done), 1);
    chk(in_ready == 1'b1, "R7", "in_ready with done", int'(in_ready), 1);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle only", int'(done), 0);
  endtask

  task automatic load_case(input int c);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = TAB_A[c][i*N + j];
        mb[i][j] = TAB_B[c][i*N + j];
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_a = '0;
    in_b = '0;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);

    // table walk: plain, R10 extremes, R5 stall, R8 gaps and junk
    for (int c = 0; c < NCASE; c++) begin
      load_case(c);
      run_product((c == 3) ? 2 : 0, (c == 2) ? 1 : -1, c == 1);
    end

    // R9: back-to-back products reuse the cells from clean accumulators
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          ma[i][j] = int'($signed(DW'($urandom())));
          mb[i][j] = int'($signed(DW'($urandom())));
        end
      run_product(r, r == 2 ? 0 : -1, r == 1);
    end

    // R8: junk during drain must not leak into the next product
    load_case(0);
    run_product(0, N - 1, 1'b1);
    load_case(3);
    run_product(1, -1, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule